// File: doc/BRIEF.md
# Control-Byte Stream Demultiplexer

This block sits behind a serial slave front end that has already matched the device address. The front end passes on a stream of bytes with a per-byte valid strobe and pulses that mark where each access starts and ends. The block reads the control bytes in that stream and sends each data byte to one of three write ports: the command register, the display RAM, or the PWM data store. Each port has its own registered data output and a single-cycle write enable.

The first byte of every access is a control byte. Its top bit is a continuation flag. When the flag is set, exactly one data byte follows and then another control byte is expected, so a single access can mix all three destinations. When the flag is clear, every remaining byte of the access goes to the selected destination.

Debug outputs show the parser phase, the selected destination and the continuation flag, so the parser state can be seen at the ports.

Top module: `ctrl_stream_demux`

## Requirements
- R1: While reset is held, and after it is released, no write enable is high, the debug phase is 0 (idle), the debug destination and continuation flag are 0, and every port data output is 0.
- R2: An access-start pulse makes the parser treat the next byte as a control byte, whatever phase it was in. A byte that is valid in the same cycle as the start pulse is taken as that control byte. If start and end arrive together, start wins.
- R3: In a control byte, bits 6:5 select the destination: 00 is the command port, 01 is the RAM port, 10 is the PWM port and 11 is unused. Bit 7 is the continuation flag. Bits 4:0 have no effect. From the cycle after the control byte, the debug destination shows bits 6:5 and the debug continuation output shows bit 7.
- R4: After a control byte with bit 7 at 1, exactly one data byte is routed, and the byte after it is treated as a control byte.
- R5: After a control byte with bit 7 at 0, every following byte of the access is routed to the selected destination until the access ends.
- R6: A data byte that arrives while destination code 11 is selected is consumed without strobing any port, and it leaves all data outputs unchanged.
- R7: An access-end pulse returns the parser to idle. A byte that is valid in the same cycle as the end pulse is processed first. Bytes that arrive while idle produce no write, and an access that ends right after a control byte produces no write.
- R8: Each routed data byte raises the write enable of exactly one port, for one cycle, in the cycle after its valid strobe. That port's data output then carries the byte. A data output changes only when its own port is written.
- R9: No write enable rises for a control byte.
- R10: The debug phase encodes 0 = idle, 1 = control byte expected, 2 = single data byte expected, 3 = data streaming until the end of the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_start_i | input | 1 | Pulse: a new access begins |
| acc_end_i | input | 1 | Pulse: the current access ends |
| byte_vld_i | input | 1 | Strobe: byte_i holds a byte this cycle |
| byte_i | input | 8 | Byte from the front end |
| cmd_we_o | output | 1 | Command port write enable |
| cmd_data_o | output | 8 | Command port data |
| ram_we_o | output | 1 | RAM port write enable |
| ram_data_o | output | 8 | RAM port data |
| pwm_we_o | output | 1 | PWM port write enable |
| pwm_data_o | output | 8 | PWM port data |
| dbg_phase_o | output | 2 | Parser phase (encoding in R10) |
| dbg_dest_o | output | 2 | Selected destination code |
| dbg_cont_o | output | 1 | Continuation flag of the last control byte |

## Verification
The assertions check on every cycle that at most one port is strobed, that a strobe only follows a valid byte, that control bytes and idle bytes never cause a strobe, that start and end pulses move the phase as specified, and that each data output holds when its port is not written. What the assertions cannot show is the routing itself: which port a given byte reaches, and whether the single-byte and streaming modes hand over correctly across mixed accesses. The bench shows this with a reference model that runs over directed sequences and a long random stream of starts, ends and bytes.

// File: rtl/csd_pkg.sv
package csd_pkg;
  localparam int BYTE_W   = 8;
  localparam int NUM_DEST = 3;
  localparam int SEL_W    = 2;
  localparam int CONT_BIT = 7;
  localparam int SEL_HI   = 6;
  localparam int SEL_LO   = 5;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_CTRL   = 2'd1,
    PH_ONE    = 2'd2,
    PH_STREAM = 2'd3
  } phase_e;
endpackage

// File: rtl/csd_parser.sv
module csd_parser
  import csd_pkg::*;
#(
  parameter int W  = BYTE_W,
  parameter int SW = SEL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_start_i,
  input  logic          acc_end_i,
  input  logic          byte_vld_i,
  input  logic [W-1:0]  byte_i,
  output logic          wr_req_o,
  output logic [SW-1:0] wr_sel_o,
  output phase_e        phase_o,
  output logic [SW-1:0] sel_o,
  output logic          cont_o
);
  phase_e          phase_q, phase_d, eff_phase;
  logic [SW-1:0]   sel_q, sel_d;
  logic            cont_q, cont_d;
  logic            state_en;

  assign state_en = byte_vld_i | acc_start_i | acc_end_i;

  always_comb begin
    eff_phase = acc_start_i ? PH_CTRL : phase_q;
    phase_d   = eff_phase;
    sel_d     = sel_q;
    cont_d    = cont_q;
    wr_req_o  = 1'b0;
    wr_sel_o  = sel_q;
    if (byte_vld_i) begin
      case (eff_phase)
        PH_CTRL: begin
          sel_d   = byte_i[SEL_HI:SEL_LO];
          cont_d  = byte_i[CONT_BIT];
          phase_d = byte_i[CONT_BIT] ? PH_ONE : PH_STREAM;
        end
        PH_ONE: begin
          wr_req_o = 1'b1;
          phase_d  = PH_CTRL;
        end
        PH_STREAM: begin
          wr_req_o = 1'b1;
        end
        default: ;
      endcase
    end
    if (acc_end_i && !acc_start_i) begin
      phase_d = PH_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      sel_q   <= '0;
      cont_q  <= 1'b0;
    end else if (state_en) begin
      phase_q <= phase_d;
      sel_q   <= sel_d;
      cont_q  <= cont_d;
    end
  end

  assign phase_o = phase_q;
  assign sel_o   = sel_q;
  assign cont_o  = cont_q;
endmodule

// File: rtl/csd_router.sv
module csd_router #(
  parameter int W  = 8,
  parameter int N  = 3,
  parameter int SW = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_req_i,
  input  logic [SW-1:0]       wr_sel_i,
  input  logic [W-1:0]        wr_byte_i,
  output logic [N-1:0]        we_o,
  output logic [N-1:0][W-1:0] data_o
);
  for (genvar g = 0; g < N; g++) begin : g_port
    logic hit;
    assign hit = wr_req_i && (wr_sel_i == SW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        we_o[g] <= 1'b0;
      end else begin
        we_o[g] <= hit;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_o[g] <= '0;
      end else if (hit) begin
        data_o[g] <= wr_byte_i;
      end
    end
  end
endmodule

// File: rtl/ctrl_stream_demux.sv
module ctrl_stream_demux
  import csd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_start_i,
  input  logic              acc_end_i,
  input  logic              byte_vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              cmd_we_o,
  output logic [BYTE_W-1:0] cmd_data_o,
  output logic              ram_we_o,
  output logic [BYTE_W-1:0] ram_data_o,
  output logic              pwm_we_o,
  output logic [BYTE_W-1:0] pwm_data_o,
  output logic [1:0]        dbg_phase_o,
  output logic [SEL_W-1:0]  dbg_dest_o,
  output logic              dbg_cont_o
);
  logic                           wr_req;
  logic [SEL_W-1:0]               wr_sel;
  phase_e                         phase;
  logic [NUM_DEST-1:0]            we;
  logic [NUM_DEST-1:0][BYTE_W-1:0] data;

  csd_parser #(.W(BYTE_W), .SW(SEL_W)) u_parser (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_start_i (acc_start_i),
    .acc_end_i   (acc_end_i),
    .byte_vld_i  (byte_vld_i),
    .byte_i      (byte_i),
    .wr_req_o    (wr_req),
    .wr_sel_o    (wr_sel),
    .phase_o     (phase),
    .sel_o       (dbg_dest_o),
    .cont_o      (dbg_cont_o)
  );

  csd_router #(.W(BYTE_W), .N(NUM_DEST), .SW(SEL_W)) u_router (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_req_i  (wr_req),
    .wr_sel_i  (wr_sel),
    .wr_byte_i (byte_i),
    .we_o      (we),
    .data_o    (data)
  );

  assign dbg_phase_o = phase;
  assign cmd_we_o    = we[0];
  assign ram_we_o    = we[1];
  assign pwm_we_o    = we[2];
  assign cmd_data_o  = data[0];
  assign ram_data_o  = data[1];
  assign pwm_data_o  = data[2];
endmodule

// File: rtl/csd_checker.sv
module csd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       acc_start_i,
  input logic       acc_end_i,
  input logic       byte_vld_i,
  input logic       cmd_we_o,
  input logic [7:0] cmd_data_o,
  input logic       ram_we_o,
  input logic [7:0] ram_data_o,
  input logic       pwm_we_o,
  input logic [7:0] pwm_data_o,
  input logic [1:0] dbg_phase_o
);
  logic any_we;
  assign any_we = cmd_we_o | ram_we_o | pwm_we_o;

  // R8
  onehot_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_we_o, ram_we_o, pwm_we_o}));

  // R8
  we_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_we |-> $past(byte_vld_i));

  // R9
  no_ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld_i && (acc_start_i || dbg_phase_o == 2'd1)) |=> !any_we);

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld_i && !acc_start_i && dbg_phase_o == 2'd0) |=> !any_we);

  // R7
  end_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_end_i && !acc_start_i) |=> dbg_phase_o == 2'd0);

  // R2
  start_to_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_start_i && !byte_vld_i) |=> dbg_phase_o == 2'd1);

  // R8
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_we_o |-> $stable(cmd_data_o));

  // R8
  ram_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_we_o |-> $stable(ram_data_o));

  // R8
  pwm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_we_o |-> $stable(pwm_data_o));
endmodule

bind ctrl_stream_demux csd_checker u_csd_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .acc_start_i (acc_start_i),
  .acc_end_i   (acc_end_i),
  .byte_vld_i  (byte_vld_i),
  .cmd_we_o    (cmd_we_o),
  .cmd_data_o  (cmd_data_o),
  .ram_we_o    (ram_we_o),
  .ram_data_o  (ram_data_o),
  .pwm_we_o    (pwm_we_o),
  .pwm_data_o  (pwm_data_o),
  .dbg_phase_o (dbg_phase_o)
);

// File: tb/ctrl_stream_demux_bench.sv
module ctrl_stream_demux_bench;
  logic       clk;
  logic       rst_n;
  logic       acc_start_i, acc_end_i, byte_vld_i;
  logic [7:0] byte_i;
  logic       cmd_we_o, ram_we_o, pwm_we_o;
  logic [7:0] cmd_data_o, ram_data_o, pwm_data_o;
  logic [1:0] dbg_phase_o, dbg_dest_o;
  logic       dbg_cont_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // reference model state
  int         m_ph;
  logic [1:0] m_sel;
  logic       m_cont;
  logic [2:0] e_we;
  logic [7:0] e_dat [3];

  ctrl_stream_demux u_ctrl_stream_demux (
    .clk, .rst_n, .acc_start_i, .acc_end_i, .byte_vld_i, .byte_i,
    .cmd_we_o, .cmd_data_o, .ram_we_o, .ram_data_o, .pwm_we_o, .pwm_data_o,
    .dbg_phase_o, .dbg_dest_o, .dbg_cont_o
  );

  initial clk = 0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk({pwm_we_o, ram_we_o, cmd_we_o} == e_we, tag, "we",
        int'({pwm_we_o, ram_we_o, cmd_we_o}), int'(e_we));
    chk(cmd_data_o == e_dat[0] && ram_data_o == e_dat[1] && pwm_data_o == e_dat[2],
        tag, "data", int'({cmd_data_o, ram_data_o, pwm_data_o}),
        int'({e_dat[0], e_dat[1], e_dat[2]}));
    chk(int'(dbg_phase_o) == m_ph, tag, "phase", int'(dbg_phase_o), m_ph);
    chk(dbg_dest_o == m_sel && dbg_cont_o == m_cont, tag, "dest/cont",
        int'({dbg_cont_o, dbg_dest_o}), int'({m_cont, m_sel}));
  endtask

  // one clock cycle: drive at negedge, model, check at next negedge
  task automatic cyc(input bit s, input bit e, input bit v, input logic [7:0] b,
                     input string tag);
    int eff, nph;
    bit wr;
    acc_start_i = s; acc_end_i = e; byte_vld_i = v; byte_i = b;
    eff = s ? 1 : m_ph;
    nph = eff;
    wr  = 0;
    e_we = 3'b000;
    if (v) begin
      case (eff)
        1: begin m_sel = b[6:5]; m_cont = b[7]; nph = b[7] ? 2 : 3; end
        2: begin wr = 1; nph = 1; end
        3: wr = 1;
        default: ;
      endcase
    end
    if (e && !s) nph = 0;
    if (wr && m_sel != 2'b11) begin
      e_we[m_sel] = 1'b1;
      e_dat[m_sel] = b;
    end
    m_ph = nph;
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    m_ph = 0; m_sel = 0; m_cont = 0; e_we = 0;
    for (int i = 0; i < 3; i++) e_dat[i] = 8'h00;
    acc_start_i = 0; acc_end_i = 0; byte_vld_i = 0; byte_i = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    check_all("R1 in reset");
    rst_n = 1;
    @(negedge clk);
    check_all("R1 after reset");

    // R7: bytes while idle do nothing
    cyc(0, 0, 1, 8'h20, "R7 idle byte");
    cyc(0, 0, 1, 8'h33, "R7 idle byte");

    // R3 R4 R9: mixed access with continuation set
    cyc(1, 0, 0, 8'h00, "R2 start");
    cyc(0, 0, 1, 8'h80, "R9 ctrl cmd cont");
    cyc(0, 0, 1, 8'hAA, "R4 cmd data");
    cyc(0, 0, 1, 8'hA0, "R9 ctrl ram cont");
    cyc(0, 0, 1, 8'h55, "R4 ram data");
    cyc(0, 0, 1, 8'h40, "R3 ctrl pwm last");
    // R5: streaming
    cyc(0, 0, 1, 8'h11, "R5 pwm stream");
    cyc(0, 0, 0, 8'h00, "R10 gap");
    cyc(0, 0, 1, 8'h22, "R5 pwm stream");
    cyc(0, 1, 1, 8'h33, "R7 byte with end");
    cyc(0, 0, 1, 8'h44, "R7 after end");

    // R3: low bits ignored
    cyc(1, 0, 1, 8'h1F, "R2 start with ctrl byte");
    cyc(0, 0, 1, 8'h77, "R3 cmd data low bits ignored");
    cyc(0, 0, 1, 8'h78, "R5 cmd stream");

    // R2: restart mid-stream with same-cycle control byte
    cyc(1, 0, 1, 8'h20, "R2 restart ctrl ram");
    cyc(0, 0, 1, 8'h5A, "R2 ram data");
    cyc(1, 1, 0, 8'h00, "R2 start beats end");

    // R6: unused destination
    cyc(0, 0, 1, 8'hE3, "R6 ctrl unused cont");
    cyc(0, 0, 1, 8'h99, "R6 dropped byte");
    cyc(0, 0, 1, 8'h60, "R6 ctrl unused last");
    cyc(0, 0, 1, 8'h98, "R6 dropped byte");
    cyc(0, 0, 1, 8'h97, "R6 dropped byte");

    // R7: end right after control byte
    cyc(0, 1, 0, 8'h00, "R7 end");
    cyc(1, 0, 1, 8'h40, "R7 ctrl then end");
    cyc(0, 1, 0, 8'h00, "R7 end no data");
    cyc(0, 0, 0, 8'h00, "R10 idle");

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      int r;
      bit s, e, v;
      logic [7:0] b;
      r = int'($urandom % 100);
      s = (r < 5);
      r = int'($urandom % 100);
      e = (r < 5);
      r = int'($urandom % 100);
      v = (r < 70);
      b = 8'($urandom);
      cyc(s, e, v, b, "R8 random");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule